// File: doc/BRIEF.md
# Single-Channel DMA Request Handshake

This block sits on the peripheral side of one DMA channel on an 8-bit expansion bus. The peripheral posts a transfer request with a one-cycle pulse. The block raises the bus request line and holds it until the controller's active-low acknowledge arrives. It remembers a small number of further requests and keeps the request line asserted while any of them are outstanding.

While the acknowledge is low and the controller owns the bus, the I/O read and write strobes select this peripheral directly, with no address decode. A read strobe makes the block drive the peripheral's byte onto the bus. The trailing edge of a write strobe captures the bus byte for the peripheral. A terminal-count pulse seen during an acknowledged cycle sets a sticky block-complete flag. The peripheral clears that flag, and while it is set, the request line is held low and new requests are discarded.

All bus inputs are assumed to be already synchronous to `clk`, and the strobes are active low.

Top module: `isa_dma_handshake`

## Requirements
- R1: While `rst_n` is low at a clock edge, `drq_o`, `done_o` and `wr_valid_o` are 0 after that edge, and the outstanding-request count is cleared, so `drq_o` stays 0 after reset until a new request.
- R2: A `req_i` pulse while `done_o` is 0 and no request is outstanding makes `drq_o` 1 from the next cycle.
- R3: Once `drq_o` is 1, it stays 1 in every cycle in which `dack_n_i` is sampled high.
- R4: Each high-to-low transition of `dack_n_i` retires one outstanding request. `drq_o` goes to 0 in the cycle after the transition if that was the last request, and stays 1 otherwise.
- R5: `tc_i` high while `dack_n_i` is 0 and `aen_i` is 1 sets `done_o` from the next cycle. `done_o` then holds until a cycle with `done_clr_i` high. If the set condition and `done_clr_i` coincide, the set wins.
- R6: While `done_o` is 1, `drq_o` is 0 and `req_i` pulses are discarded, so clearing `done_o` does not raise `drq_o` for them.
- R7: `bus_d_oe_o` is 1 exactly when `dack_n_i` is 0, `aen_i` is 1 and `ior_n_i` is 0 (combinational). While it is 1, `bus_d_o` equals `rd_data_i`.
- R8: On a low-to-high transition of `iow_n_i` while `dack_n_i` is 0 and `aen_i` is 1, `wr_valid_o` is 1 for exactly one cycle, starting in the cycle after the transition. In that cycle `wr_data_o` holds `bus_d_i` as sampled in the last cycle in which `iow_n_i` was low.
- R9: Strobes and `tc_i` have no effect when `dack_n_i` is 1 or `aen_i` is 0. In that case there is no write capture, no bus drive and no change of `done_o`.
- R10: The outstanding-request count saturates at 2**PEND_W-1 (3 by default), and requests beyond that are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Peripheral transfer request pulse |
| done_clr_i | input | 1 | Clears the block-complete flag |
| done_o | output | 1 | Block-complete flag (sticky) |
| drq_o | output | 1 | Bus DMA request |
| dack_n_i | input | 1 | Bus DMA acknowledge, active low |
| aen_i | input | 1 | Bus owned by DMA controller |
| tc_i | input | 1 | Terminal-count pulse |
| ior_n_i | input | 1 | I/O read strobe, active low |
| iow_n_i | input | 1 | I/O write strobe, active low |
| bus_d_i | input | DATA_W | Bus data in |
| bus_d_o | output | DATA_W | Bus data out |
| bus_d_oe_o | output | 1 | Bus data output enable |
| rd_data_i | input | DATA_W | Byte supplied by the peripheral |
| wr_data_o | output | DATA_W | Byte captured from the bus |
| wr_valid_o | output | 1 | Captured byte valid pulse |

## Verification
The terminal-count set of the done flag and the peripheral's clear request can land on the same edge. The bench provokes this by holding `tc_i` and `done_clr_i` high together during an acknowledged cycle, and it expects `done_o` to remain 1 afterwards. A second overlap occurs when an acknowledge retires a request while others are still queued. Here the bench queues two or more requests and expects `drq_o` to stay high across each acknowledge until the last one.

// File: rtl/isa_dma_pkg.sv
// Shared constants for the DMA handshake block.
// Assumes: all bus lines are synchronous to the block clock.
package isa_dma_pkg;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_PEND_W = 2;
endpackage

// File: rtl/dma_req_ctrl.sv
// Request side: counts outstanding requests, drives the bus request and
// keeps the sticky block-complete flag.
// Assumes: dack_n and tc are synchronous; requests are one-cycle pulses.
module dma_req_ctrl #(
    parameter int PEND_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic done_clr,
    input  logic dack_n,
    input  logic sel,
    input  logic tc,
    output logic drq,
    output logic done
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] pend_q, pend_nx;
    logic              dack_q;
    logic              done_nx;
    logic              inc, dec;

    // Next outstanding count and done flag.
    always_comb begin
        dec     = dack_q && !dack_n && (pend_q != '0);
        inc     = req && !done && ((pend_q != PEND_MAX) || dec);
        pend_nx = pend_q + PEND_W'(inc) - PEND_W'(dec);
        if (sel && tc)
            done_nx = 1'b1;
        else if (done_clr)
            done_nx = 1'b0;
        else
            done_nx = done;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            dack_q <= 1'b1;
            done   <= 1'b0;
            drq    <= 1'b0;
        end else begin
            pend_q <= pend_nx;
            dack_q <= dack_n;
            done   <= done_nx;
            drq    <= (pend_nx != '0) && !done_nx;
        end
    end
endmodule

// File: rtl/dma_data_path.sv
// Data side: drives the peripheral byte on acknowledged reads and captures
// the bus byte at the trailing edge of an acknowledged write strobe.
// Assumes: sel already combines acknowledge and bus ownership.
module dma_data_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [DATA_W-1:0] bus_d_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_valid
);
    logic              iow_q;
    logic [DATA_W-1:0] d_hold;

    // Read drive is combinational from the strobes.
    always_comb begin
        bus_d_oe  = sel && !ior_n;
        bus_d_out = rd_data;
    end

    // Hold the bus byte while the write strobe is low; emit it on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iow_q    <= 1'b1;
            d_hold   <= '0;
            wr_data  <= '0;
            wr_valid <= 1'b0;
        end else begin
            iow_q    <= iow_n;
            if (!iow_n)
                d_hold <= bus_d_in;
            wr_valid <= sel && iow_n && !iow_q;
            if (sel && iow_n && !iow_q)
                wr_data <= d_hold;
        end
    end
endmodule

// File: rtl/isa_dma_handshake.sv
// Top: one-channel peripheral-side DMA handshake. Selection comes from the
// acknowledge line qualified by bus ownership, not from an address decode.
// Assumes: bus inputs synchronous to clk; strobes and acknowledge active low.
module isa_dma_handshake
    import isa_dma_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PEND_W = DEF_PEND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              done_clr_i,
    output logic              done_o,
    output logic              drq_o,
    input  logic              dack_n_i,
    input  logic              aen_i,
    input  logic              tc_i,
    input  logic              ior_n_i,
    input  logic              iow_n_i,
    input  logic [DATA_W-1:0] bus_d_i,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_d_oe_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_valid_o
);
    logic sel;

    // Channel selected: granted and controller owns the bus.
    always_comb sel = !dack_n_i && aen_i;

    dma_req_ctrl #(.PEND_W(PEND_W)) u_req (
        .clk(clk), .rst_n(rst_n), .req(req_i), .done_clr(done_clr_i),
        .dack_n(dack_n_i), .sel(sel), .tc(tc_i), .drq(drq_o), .done(done_o)
    );

    dma_data_path #(.DATA_W(DATA_W)) u_dat (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ior_n(ior_n_i), .iow_n(iow_n_i),
        .bus_d_in(bus_d_i), .rd_data(rd_data_i), .bus_d_out(bus_d_o),
        .bus_d_oe(bus_d_oe_o), .wr_data(wr_data_o), .wr_valid(wr_valid_o)
    );
endmodule

// File: rtl/isa_dma_handshake_chk.sv
// Checker for the handshake block, bound to every instance of the top.
// Assumes: same clock and synchronous reset as the block.
module isa_dma_handshake_chk (
    input logic clk,
    input logic rst_n,
    input logic done_clr_i,
    input logic done_o,
    input logic drq_o,
    input logic dack_n_i,
    input logic aen_i,
    input logic tc_i,
    input logic bus_d_oe_o,
    input logic wr_valid_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!drq_o && !done_o && !wr_valid_o)); // R1
    AST_DRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (drq_o && dack_n_i) |=> drq_o); // R3
    AST_TC_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n) (tc_i && !dack_n_i && aen_i) |=> done_o); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !done_clr_i) |=> done_o); // R5
    AST_DONE_MASKS_DRQ: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !drq_o); // R6
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wr_valid_o |=> !wr_valid_o); // R8
    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n) bus_d_oe_o |-> (!dack_n_i && aen_i)); // R9
endmodule

bind isa_dma_handshake isa_dma_handshake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .done_clr_i(done_clr_i), .done_o(done_o),
    .drq_o(drq_o), .dack_n_i(dack_n_i), .aen_i(aen_i), .tc_i(tc_i),
    .bus_d_oe_o(bus_d_oe_o), .wr_valid_o(wr_valid_o)
);

// File: tb/tb_isa_dma_handshake.sv
module tb_isa_dma_handshake;
    logic clk = 1'b0;
    logic rst_n, req_i, done_clr_i, done_o, drq_o, dack_n_i, aen_i, tc_i;
    logic ior_n_i, iow_n_i, bus_d_oe_o, wr_valid_o;
    logic [7:0] bus_d_i, bus_d_o, rd_data_i, wr_data_o;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    isa_dma_handshake dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_clr_i(done_clr_i),
        .done_o(done_o), .drq_o(drq_o), .dack_n_i(dack_n_i), .aen_i(aen_i),
        .tc_i(tc_i), .ior_n_i(ior_n_i), .iow_n_i(iow_n_i), .bus_d_i(bus_d_i),
        .bus_d_o(bus_d_o), .bus_d_oe_o(bus_d_oe_o), .rd_data_i(rd_data_i),
        .wr_data_o(wr_data_o), .wr_valid_o(wr_valid_o)
    );

    // Vector: dack_n, aen, ior_n, rd_data, expected oe
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 1'b1, 1'b0, 8'h5A, 1'b1},
        {1'b0, 1'b1, 1'b1, 8'h11, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'h22, 1'b0},
        {1'b0, 1'b0, 1'b0, 8'h33, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'h44, 1'b0},
        {1'b0, 1'b1, 1'b0, 8'hC3, 1'b1},
        {1'b1, 1'b1, 1'b1, 8'h66, 1'b0},
        {1'b0, 1'b1, 1'b0, 8'h00, 1'b1}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic req_pulse();
        req_i = 1'b1;
        tick();
        req_i = 1'b0;
    endtask

    task automatic ack();
        dack_n_i = 1'b0;
        tick();
        dack_n_i = 1'b1;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_i = 1'b0; done_clr_i = 1'b0; dack_n_i = 1'b1;
        aen_i = 1'b0; tc_i = 1'b0; ior_n_i = 1'b1; iow_n_i = 1'b1;
        bus_d_i = 8'h00; rd_data_i = 8'h00;
        @(negedge clk);
        req_i = 1'b1;
        tick(); tick();
        req_i = 1'b0;
        tick();
        check(!drq_o && !done_o && !wr_valid_o, "R1 reset outputs", {drq_o, done_o, wr_valid_o}, 0);
        rst_n = 1'b1;
        tick(); tick();
        check(!drq_o, "R1 no request after reset", drq_o, 0);

        // R7 / R9 read drive vectors
        for (int i = 0; i < 8; i++) begin
            dack_n_i = VEC[i][11]; aen_i = VEC[i][10]; ior_n_i = VEC[i][9];
            rd_data_i = VEC[i][8:1];
            #1;
            check(bus_d_oe_o == VEC[i][0], "R7 R9 read drive enable", bus_d_oe_o, VEC[i][0]);
            if (VEC[i][0])
                check(bus_d_o == VEC[i][8:1], "R7 read data", bus_d_o, VEC[i][8:1]);
        end
        dack_n_i = 1'b1; aen_i = 1'b1; ior_n_i = 1'b1;
        tick();

        // R2 / R3 / R4 single request
        req_pulse();
        check(drq_o, "R2 drq raised", drq_o, 1);
        for (int i = 0; i < 5; i++) begin
            tick();
            check(drq_o, "R3 drq held", drq_o, 1);
        end
        ack();
        check(!drq_o, "R4 drq dropped after ack", drq_o, 0);
        tick();

        // R4 two outstanding
        req_pulse(); req_pulse();
        ack();
        check(drq_o, "R4 drq kept with one left", drq_o, 1);
        tick();
        ack();
        check(!drq_o, "R4 drq dropped after last", drq_o, 0);
        tick();

        // R8 write capture
        dack_n_i = 1'b0; iow_n_i = 1'b0; bus_d_i = 8'hA5;
        tick();
        bus_d_i = 8'h3C;
        tick();
        iow_n_i = 1'b1; bus_d_i = 8'hFF;
        tick();
        check(wr_valid_o, "R8 write valid", wr_valid_o, 1);
        check(wr_data_o == 8'h3C, "R8 write data", wr_data_o, 8'h3C);
        tick();
        check(!wr_valid_o, "R8 single pulse", wr_valid_o, 0);

        // R9 strobes without selection
        aen_i = 1'b0; iow_n_i = 1'b0;
        tick();
        iow_n_i = 1'b1;
        tick();
        check(!wr_valid_o, "R9 no capture without aen", wr_valid_o, 0);
        aen_i = 1'b1; dack_n_i = 1'b1; iow_n_i = 1'b0;
        tick();
        iow_n_i = 1'b1; tc_i = 1'b1;
        tick();
        tc_i = 1'b0;
        check(!wr_valid_o, "R9 no capture without dack", wr_valid_o, 0);
        check(!done_o, "R9 tc ignored without dack", done_o, 0);

        // R5 terminal count
        req_pulse();
        dack_n_i = 1'b0; tc_i = 1'b1;
        tick();
        tc_i = 1'b0; dack_n_i = 1'b1;
        check(done_o, "R5 done set", done_o, 1);
        check(!drq_o, "R6 drq low while done", drq_o, 0);
        tick(); tick();
        check(done_o, "R5 done sticky", done_o, 1);

        // R6 requests dropped while done
        req_pulse();
        check(!drq_o, "R6 drq masked", drq_o, 0);
        done_clr_i = 1'b1;
        tick();
        done_clr_i = 1'b0;
        check(!done_o, "R5 done cleared", done_o, 0);
        tick();
        check(!drq_o, "R6 dropped request not revived", drq_o, 0);

        // R5 set and clear in the same cycle
        dack_n_i = 1'b0; tc_i = 1'b1; done_clr_i = 1'b1;
        tick();
        dack_n_i = 1'b1; tc_i = 1'b0; done_clr_i = 1'b0;
        check(done_o, "R5 set wins over clear", done_o, 1);
        done_clr_i = 1'b1;
        tick();
        done_clr_i = 1'b0;
        tick();

        // R10 saturation at three
        req_pulse(); req_pulse(); req_pulse(); req_pulse();
        ack(); tick();
        check(drq_o, "R10 after first ack", drq_o, 1);
        ack(); tick();
        check(drq_o, "R10 after second ack", drq_o, 1);
        ack();
        check(!drq_o, "R10 fourth request dropped", drq_o, 0);
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule